// File: doc/BRIEF.md
# Horizontally Microcoded 16-bit Datapath

This block is a 16-bit datapath steered entirely by a writable horizontal control store. Every 32-bit control word sets all control lines for one major cycle. In that cycle the word picks two scratchpad operands, runs them through a four-function ALU and a one-bit shifter, and can write the result back into the scratchpad. It can also load the memory address register (MAR) and the memory buffer register (MBR), raise the read or write strobe, and choose the next control-store address.

The control store is loaded through a simple write port while `run` is low. Execution advances one control word per clock while `run` is high. A small state machine tracks the memory protocol, in which every access holds its strobe over two consecutive control words. Any break in that pairing sets a sticky error flag.

Memory-protocol state machine: `MEM_IDLE` goes to `MEM_RD_HALF` on a lone read strobe and to `MEM_WR_HALF` on a lone write strobe. Both strobes together in `MEM_IDLE` raise the error and stay in `MEM_IDLE`. `MEM_RD_HALF` returns to `MEM_IDLE`; it completes the read when the next word repeats the read strobe alone, and otherwise raises the error. `MEM_WR_HALF` returns to `MEM_IDLE` in the same way for writes. While `run` is low the state machine holds its state.

Top module: `mc_datapath`

## Requirements
- R1: After reset, upc, MAR and MBR are zero, the error flag is low, and the scratchpad holds 0x0001 in register 6, 0xFFFF in register 7, 0x0FFF in register 8, 0x00FF in register 9 and zero elsewhere.
- R2: Control word bits, MSB first: amux[31], cond[30:29], alu[28:27], sh[26:25], mbr[24], mar[23], rd[22], wr[21], enc[20], c[19:16], b[15:12], a[11:8], addr[7:0].
- R3: The alu field selects 0 = A+B (mod 2^16), 1 = A AND B, 2 = A, 3 = NOT A.
- R4: The sh field selects 0 = no shift, 1 = logical right shift by one, 2 = left shift by one, 3 = no shift.
- R5: n_flag is bit 15 of the ALU result and z_flag is high when the ALU result is zero; the shifter never changes either flag.
- R6: cond 0 = fall through, 1 = branch if N, 2 = branch if Z, 3 = always branch. A taken branch loads upc with addr on the same clock; otherwise upc increments, wrapping from 0xFF to 0x00.
- R7: amux=1 feeds MBR to the ALU A input; amux=0 feeds scratchpad register a.
- R8: enc=1 writes the shifter output into scratchpad register c; with enc=0 no register changes.
- R9: mar=1 loads MAR with the low 12 bits of scratchpad register b.
- R10: mbr=1 loads the shifter output into MBR. A read completes on the second of two consecutive rd words and then loads MBR from mem_rdata, unless the same word has mbr=1, which wins.
- R11: mem_rd and mem_wr equal the rd and wr fields while run is high. A lone rd or lone wr not repeated in the very next word, or rd and wr in the same word, sets proto_err, and proto_err stays set until reset.
- R12: While run is low, upc, MAR, MBR, the scratchpad and the protocol state hold, and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute one control word per clock when high |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 8 | Control-store write address |
| cs_wdata | input | 32 | Control-store write word |
| mem_rdata | input | 16 | Memory read data, captured on read completion |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 12 | MAR contents |
| mem_wdata | output | 16 | MBR contents |
| upc | output | 8 | Current control-store address |
| n_flag | output | 1 | Negative flag of the current ALU result |
| z_flag | output | 1 | Zero flag of the current ALU result |
| proto_err | output | 1 | Sticky memory-protocol error |

## Verification
Two of this block's functions can load MBR in the same cycle: a read completing on its second rd word, and that same word asking for the shifter output with mbr=1. The bench builds a read pair whose second word also sets mbr and passes the constant register 6. It judges the result by requiring MBR to hold 0x0001 rather than the value on mem_rdata, then repeats the pair without mbr to show that the read path alone still loads mem_rdata. A second overlap, a branch decided in the same cycle the shifter alters the value, is provoked by shifting a negative or non-zero value to a different sign or to zero. The branch must follow the unshifted ALU result.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int UI_W = 32;

    localparam int REG_ONE   = 6;
    localparam int REG_MONE  = 7;
    localparam int REG_AMASK = 8;
    localparam int REG_SMASK = 9;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_AND  = 2'd1,
        ALU_PASS = 2'd2,
        ALU_NOT  = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_LEFT  = 2'd2,
        SH_RSVD  = 2'd3
    } sh_op_e;

    typedef enum logic [1:0] {
        BR_NEVER  = 2'd0,
        BR_NEG    = 2'd1,
        BR_ZERO   = 2'd2,
        BR_ALWAYS = 2'd3
    } br_cond_e;

    typedef enum logic [1:0] {
        MEM_IDLE    = 2'd0,
        MEM_RD_HALF = 2'd1,
        MEM_WR_HALF = 2'd2
    } mem_state_e;

    // Field order is fixed: the sequencer and datapath decode these positions.
    typedef struct packed {
        logic       amux;
        br_cond_e   cond;
        alu_op_e    alu;
        sh_op_e     sh;
        logic       ld_mbr;
        logic       ld_mar;
        logic       rd;
        logic       wr;
        logic       enc;
        logic [3:0] c;
        logic [3:0] b;
        logic [3:0] a;
        logic [7:0] addr;
    } uinstr_t;

endpackage

// File: rtl/mc_ustore.sv
module mc_ustore #(
    parameter int UPC_W = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [UPC_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [UPC_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << UPC_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mc_scratch.sv
module mc_scratch
    import mc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    parameter int MAR_W  = 12,
    parameter int OFF_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [$clog2(NREG)-1:0] raddr_a,
    input  logic [$clog2(NREG)-1:0] raddr_b,
    output logic [DATA_W-1:0]       rd_a,
    output logic [DATA_W-1:0]       rd_b
);
    localparam logic [DATA_W-1:0] AMASK = {{(DATA_W-MAR_W){1'b0}}, {MAR_W{1'b1}}};
    localparam logic [DATA_W-1:0] SMASK = {{(DATA_W-OFF_W){1'b0}}, {OFF_W{1'b1}}};

    logic [DATA_W-1:0] regs [NREG];

    function automatic logic [DATA_W-1:0] boot_val(input int idx);
        case (idx)
            REG_ONE:   return DATA_W'(1);
            REG_MONE:  return {DATA_W{1'b1}};
            REG_AMASK: return AMASK;
            REG_SMASK: return SMASK;
            default:   return '0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= boot_val(i);
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd_a = regs[raddr_a];
    assign rd_b = regs[raddr_b];
endmodule

// File: rtl/mc_alu_shift.sv
module mc_alu_shift
    import mc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  alu_op_e           op,
    input  sh_op_e            sh,
    output logic [DATA_W-1:0] alu_res,
    output logic [DATA_W-1:0] sh_out,
    output logic              neg,
    output logic              zero
);
    always_comb begin
        unique case (op)
            ALU_ADD:  alu_res = a_in + b_in;
            ALU_AND:  alu_res = a_in & b_in;
            ALU_PASS: alu_res = a_in;
            ALU_NOT:  alu_res = ~a_in;
        endcase
    end

    always_comb begin
        unique case (sh)
            SH_RIGHT: sh_out = alu_res >> 1;
            SH_LEFT:  sh_out = alu_res << 1;
            SH_NONE,
            SH_RSVD:  sh_out = alu_res;
        endcase
    end

    assign neg  = alu_res[DATA_W-1];
    assign zero = (alu_res == '0);
endmodule

// File: rtl/mc_mem_fsm.sv
module mc_mem_fsm
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rd,
    input  logic wr,
    output logic rd_done,
    output logic proto_err
);
    mem_state_e state_q, state_d;
    logic       err_set;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= MEM_IDLE;
            proto_err <= 1'b0;
        end else begin
            state_q <= state_d;
            if (err_set) proto_err <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        rd_done = 1'b0;
        err_set = 1'b0;
        if (run) begin
            unique case (state_q)
                MEM_IDLE: begin
                    if (rd && wr) err_set = 1'b1;
                    else if (rd)  state_d = MEM_RD_HALF;
                    else if (wr)  state_d = MEM_WR_HALF;
                end
                MEM_RD_HALF: begin
                    state_d = MEM_IDLE;
                    if (rd && !wr) rd_done = 1'b1;
                    else           err_set = 1'b1;
                end
                MEM_WR_HALF: begin
                    state_d = MEM_IDLE;
                    if (!(wr && !rd)) err_set = 1'b1;
                end
                default: state_d = MEM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MAR_W  = 12,
    parameter int OFF_W  = 8,
    parameter int NREG   = 16,
    parameter int UPC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cs_we,
    input  logic [UPC_W-1:0]  cs_waddr,
    input  logic [UI_W-1:0]   cs_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [MAR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [UPC_W-1:0]  upc,
    output logic              n_flag,
    output logic              z_flag,
    output logic              proto_err
);
    logic [UI_W-1:0]   ui_word;
    uinstr_t           ui;
    logic [DATA_W-1:0] reg_a, b_bus, a_bus, alu_res, sh_out;
    logic [MAR_W-1:0]  mar_q;
    logic [DATA_W-1:0] mbr_q;
    logic [UPC_W-1:0]  upc_q;
    logic              take, rd_done;

    mc_ustore #(.UPC_W(UPC_W), .WORD_W(UI_W)) u_store (
        .clk(clk), .we(cs_we), .waddr(cs_waddr), .wdata(cs_wdata),
        .raddr(upc_q), .rdata(ui_word)
    );

    assign ui = uinstr_t'(ui_word);

    mc_scratch #(.DATA_W(DATA_W), .NREG(NREG), .MAR_W(MAR_W), .OFF_W(OFF_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(run && ui.enc), .waddr(ui.c), .wdata(sh_out),
        .raddr_a(ui.a), .raddr_b(ui.b), .rd_a(reg_a), .rd_b(b_bus)
    );

    assign a_bus = ui.amux ? mbr_q : reg_a;

    mc_alu_shift #(.DATA_W(DATA_W)) u_alu (
        .a_in(a_bus), .b_in(b_bus), .op(ui.alu), .sh(ui.sh),
        .alu_res(alu_res), .sh_out(sh_out), .neg(n_flag), .zero(z_flag)
    );

    mc_mem_fsm u_mem (
        .clk(clk), .rst_n(rst_n), .run(run), .rd(ui.rd), .wr(ui.wr),
        .rd_done(rd_done), .proto_err(proto_err)
    );

    always_comb begin
        unique case (ui.cond)
            BR_NEVER:  take = 1'b0;
            BR_NEG:    take = n_flag;
            BR_ZERO:   take = z_flag;
            BR_ALWAYS: take = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc_q <= '0;
            mar_q <= '0;
            mbr_q <= '0;
        end else if (run) begin
            upc_q <= take ? ui.addr : upc_q + 1'b1;
            if (ui.ld_mar) mar_q <= b_bus[MAR_W-1:0];
            if (ui.ld_mbr)     mbr_q <= sh_out;
            else if (rd_done)  mbr_q <= mem_rdata;
        end
    end

    assign mem_rd    = run && ui.rd;
    assign mem_wr    = run && ui.wr;
    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign upc       = upc_q;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk
    import mc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MAR_W  = 12,
    parameter int UPC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [UI_W-1:0]   ui_word,
    input logic [UPC_W-1:0]  upc,
    input logic [MAR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] b_bus,
    input logic [DATA_W-1:0] sh_out,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              proto_err
);
    uinstr_t ui;
    assign ui = uinstr_t'(ui_word);

    // R12: a paused machine keeps its visible state
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(upc) && $stable(mem_addr) && $stable(mem_wdata) && $stable(proto_err));

    // R11: strobes stay low while paused
    a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mem_rd && !mem_wr);

    // R11: error is sticky
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R6: fall-through increments
    a_r6_fall: assert property (@(posedge clk) disable iff (!rst_n)
        run && ui.cond == BR_NEVER |=> upc == $past(upc) + 1'b1);

    // R6: unconditional branch lands on addr
    a_r6_goto: assert property (@(posedge clk) disable iff (!rst_n)
        run && ui.cond == BR_ALWAYS |=> upc == $past(ui.addr));

    // R9: MAR keeps the low bits of the B bus
    a_r9_mar: assert property (@(posedge clk) disable iff (!rst_n)
        run && ui.ld_mar |=> mem_addr == $past(b_bus[MAR_W-1:0]));

    // R10: an MBR load takes the shifter output
    a_r10_mbr: assert property (@(posedge clk) disable iff (!rst_n)
        run && ui.ld_mbr |=> mem_wdata == $past(sh_out));
endmodule

bind mc_datapath mc_datapath_chk #(.DATA_W(DATA_W), .MAR_W(MAR_W), .UPC_W(UPC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .ui_word(ui_word), .upc(upc),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .b_bus(b_bus), .sh_out(sh_out),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .proto_err(proto_err)
);

// File: tb/tb_mc_datapath.sv
`timescale 1ns/1ps
module tb_mc_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cs_we = 1'b0;
    logic [7:0]  cs_waddr = '0;
    logic [31:0] cs_wdata = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd, mem_wr, n_flag, z_flag, proto_err;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [7:0]  upc;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mc_datapath dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cs_we(cs_we), .cs_waddr(cs_waddr),
        .cs_wdata(cs_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .upc(upc), .n_flag(n_flag),
        .z_flag(z_flag), .proto_err(proto_err)
    );

    // R2 field positions
    localparam logic [31:0] B_AMUX = 32'h8000_0000;
    localparam logic [31:0] B_MBR  = 32'h0100_0000;
    localparam logic [31:0] B_MAR  = 32'h0080_0000;
    localparam logic [31:0] B_RD   = 32'h0040_0000;
    localparam logic [31:0] B_WR   = 32'h0020_0000;
    localparam logic [31:0] B_ENC  = 32'h0010_0000;

    function automatic logic [31:0] f_cond(input int v); return (32'(v) & 32'h3) << 29; endfunction
    function automatic logic [31:0] f_alu(input int v);  return (32'(v) & 32'h3) << 27; endfunction
    function automatic logic [31:0] f_sh(input int v);   return (32'(v) & 32'h3) << 25; endfunction
    function automatic logic [31:0] f_c(input int v);    return (32'(v) & 32'hF) << 16; endfunction
    function automatic logic [31:0] f_b(input int v);    return (32'(v) & 32'hF) << 12; endfunction
    function automatic logic [31:0] f_a(input int v);    return (32'(v) & 32'hF) << 8;  endfunction
    function automatic logic [31:0] f_addr(input int v); return 32'(v) & 32'hFF; endfunction

    function automatic logic [15:0] boot(input int r);
        case (r)
            6: return 16'h0001;
            7: return 16'hFFFF;
            8: return 16'h0FFF;
            9: return 16'h00FF;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] e_alu(input int f, input logic [15:0] a, input logic [15:0] b);
        case (f)
            0: return a + b;
            1: return a & b;
            2: return a;
            default: return ~a;
        endcase
    endfunction

    function automatic logic [15:0] e_sh(input int s, input logic [15:0] v);
        case (s)
            1: return {1'b0, v[15:1]};
            2: return {v[14:0], 1'b0};
            default: return v;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic cs_write(input int a, input logic [31:0] w);
        cs_we = 1'b1; cs_waddr = 8'(a); cs_wdata = w;
        @(negedge clk);
        cs_we = 1'b0;
    endtask

    task automatic do_reset();
        run = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] vals [5] = '{16'h0000, 16'h8001, 16'h7FFF, 16'hFFFF, 16'h1234};
        @(negedge clk);
        do_reset();

        // R1 reset state, R9 truncation: read every register through MAR
        chk("R1 upc", 32'(upc), 32'h0);
        chk("R1 mar", 32'(mem_addr), 32'h0);
        chk("R1 mbr", 32'(mem_wdata), 32'h0);
        chk("R1 err", 32'(proto_err), 32'h0);
        chk("R11 idle strobes", 32'({mem_rd, mem_wr}), 32'h0);
        for (int k = 0; k < 16; k++) cs_write(k, B_MAR | f_b(k));
        for (int k = 0; k < 16; k++) begin
            step(1);
            chk($sformatf("R1 R9 reg%0d via mar", k), 32'(mem_addr), 32'(boot(k) & 16'h0FFF));
        end

        // R3 R4 R5 R7 sweep: MBR as A, constants as B
        do_reset();
        cs_write(0, B_RD);
        cs_write(1, B_RD);
        foreach (vals[i]) begin
            for (int f = 0; f < 4; f++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int r = 6; r < 10; r++) begin
                        logic [15:0] res;
                        res = e_alu(f, vals[i], boot(r));
                        mem_rdata = vals[i];
                        do_reset();
                        cs_write(2, B_AMUX | B_MBR | f_alu(f) | f_sh(s) | f_b(r));
                        step(2);
                        chk("R5 n_flag", 32'(n_flag), 32'(res[15]));
                        chk("R5 z_flag", 32'(z_flag), 32'(res == 16'h0));
                        step(1);
                        chk($sformatf("R3 R4 R7 f%0d s%0d r%0d", f, s, r), 32'(mem_wdata), 32'(e_sh(s, res)));
                    end
                end
            end
        end

        // R7 amux=0 picks scratchpad, R10 precedence of mbr field over read
        mem_rdata = 16'hBEEF;
        do_reset();
        cs_write(0, B_RD);
        cs_write(1, B_RD | B_MBR | f_a(6) | f_alu(2));
        cs_write(2, B_RD);
        cs_write(3, B_RD);
        cs_write(4, B_WR | B_MAR | f_b(8));
        cs_write(5, B_WR);
        cs_write(6, B_MBR | f_a(7) | f_alu(2));
        step(2);
        chk("R10 mbr field beats read", 32'(mem_wdata), 32'h0001);
        step(2);
        chk("R10 read completion", 32'(mem_wdata), 32'hBEEF);
        run = 1'b1; #1;
        chk("R11 wr strobe 1", 32'({mem_rd, mem_wr}), 32'h1);
        @(negedge clk); #1;
        chk("R11 wr strobe 2", 32'({mem_rd, mem_wr}), 32'h1);
        @(negedge clk); run = 1'b0;
        chk("R11 paired ok", 32'(proto_err), 32'h0);
        chk("R9 mask reg", 32'(mem_addr), 32'hFFF);
        step(1);
        chk("R7 amux0 reg7", 32'(mem_wdata), 32'hFFFF);

        // R8 write-back
        do_reset();
        cs_write(0, f_a(6) | f_b(6) | f_alu(0) | f_sh(2) | B_ENC | f_c(2));
        cs_write(1, f_a(7) | f_alu(2) | f_c(5));
        cs_write(2, B_MAR | f_b(2));
        cs_write(3, B_MAR | f_b(5));
        step(3);
        chk("R8 enc write", 32'(mem_addr), 32'h004);
        step(1);
        chk("R8 enc=0 no write", 32'(mem_addr), 32'h000);

        // R6 R5 branching on ALU flags, not shifter output
        do_reset();
        cs_write(8'h00, f_a(7) | f_alu(2) | f_sh(1) | f_cond(1) | f_addr(8'h40));
        cs_write(8'h40, f_a(6) | f_alu(2) | f_sh(1) | f_cond(2) | f_addr(8'h80));
        cs_write(8'h41, f_a(0) | f_alu(2) | f_cond(2) | f_addr(8'h90));
        cs_write(8'h90, f_a(6) | f_alu(2) | f_cond(1) | f_addr(8'h10));
        cs_write(8'h91, f_cond(0) | f_addr(8'h20));
        cs_write(8'h92, f_cond(3) | f_addr(8'hFF));
        cs_write(8'hFF, 32'h0);
        step(1); chk("R6 R5 neg taken", 32'(upc), 32'h40);
        step(1); chk("R6 R5 zero not taken", 32'(upc), 32'h41);
        step(1); chk("R6 zero taken", 32'(upc), 32'h90);
        step(1); chk("R6 neg not taken", 32'(upc), 32'h91);
        step(1); chk("R6 never", 32'(upc), 32'h92);
        step(1); chk("R6 always", 32'(upc), 32'hFF);
        step(1); chk("R6 wrap", 32'(upc), 32'h00);

        // R11 protocol errors
        do_reset();
        cs_write(0, B_RD);
        for (int k = 1; k < 5; k++) cs_write(k, 32'h0);
        step(2); chk("R11 lone rd", 32'(proto_err), 32'h1);
        step(3); chk("R11 sticky", 32'(proto_err), 32'h1);
        do_reset();
        chk("R1 err cleared", 32'(proto_err), 32'h0);
        cs_write(0, B_RD | B_WR);
        step(1); chk("R11 rd+wr", 32'(proto_err), 32'h1);
        do_reset();
        cs_write(0, B_RD);
        cs_write(1, B_WR);
        step(2); chk("R11 rd then wr", 32'(proto_err), 32'h1);
        do_reset();
        cs_write(0, B_WR);
        cs_write(1, 32'h0);
        step(2); chk("R11 lone wr", 32'(proto_err), 32'h1);

        // R12 pause holds everything, including a half-done read
        do_reset();
        cs_write(0, B_RD | B_MAR | f_b(7) | f_cond(3) | f_addr(8'h33));
        cs_write(8'h33, B_RD);
        #1;
        chk("R12 strobe low", 32'(mem_rd), 32'h0);
        repeat (3) @(negedge clk);
        chk("R12 upc held", 32'(upc), 32'h0);
        chk("R12 mar held", 32'(mem_addr), 32'h0);
        step(1);
        chk("R12 resume", 32'(upc), 32'h33);
        repeat (3) @(negedge clk);
        chk("R12 frozen mid-read", 32'(upc), 32'h33);
        step(1);
        chk("R12 read pair across pause", 32'(proto_err), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule